// File: doc/BRIEF.md
# Instruction Cache Line Prefetch Engine

This block raises line-fetch requests for an instruction cache ahead of the processor's demand. It has two modes of operation. In autoload mode it watches the result of each cache lookup (an address and a hit flag). When the lookup matches the configured trigger kind and its address lies inside one of two enabled address windows, the engine asks for the neighbouring line in the configured direction, but only if that line still lies inside the same window.

In manual preload mode, software gives a start address, a byte count and a direction. The engine then requests every line the region touches, one after another, and raises a done flag after the last one has been accepted. Starting a preload suspends autoload and records whether autoload had been live. Ending the preload can bring autoload back.

Requests leave through a valid/ready pair carrying a line-aligned byte address. A freeze input stops any new request from being raised. The tag update and the data refill belong to the cache and are outside this block.

Top module: `line_prefetch_engine`

## Requirements
- R1: After reset, `req_valid`, `pf_done`, `al_prior` and `al_live` are all 0.
- R2: `al_trigger` selects which lookups may trigger autoload: code 0 means misses only, code 1 means hits only, code 2 means both, and code 3 means none.
- R3: A lookup can trigger only when its address `a` satisfies `base <= a < base+size` for a window whose enable is set. Window 0 is checked before window 1.
- R4: `al_order` 0 requests the line-aligned lookup address plus one line. `al_order` 1 requests it minus one line.
- R5: No autoload request is raised when the next line falls outside the window that matched, or when it would wrap past either end of the address space.
- R6: A trigger that arrives while `req_valid` is high is dropped and not queued.
- R7: Once raised, `req_valid` and `req_addr` hold until `req_ready` is seen. `req_addr` always has its low log2(LINE_BYTES) bits at zero.
- R8: `al_live` equals `al_enable` and not suspended. An `al_suspend` pulse copies the prior `al_live` to `al_prior` and suspends autoload. An `al_resume` pulse lifts the suspension only when `al_resume_arg` is 1.
- R9: A `pf_start` pulse requests every line that overlaps the region of `pf_size` bytes starting at `pf_addr`. The size is clamped to CACHE_BYTES. Lines go lowest first when `pf_order` is 0 and highest first when it is 1. A size of 0 requests nothing.
- R10: `pf_done` rises one cycle after the last preload line has been accepted, or one cycle after starting a preload of size 0. It is cleared by `pf_start` and by `pf_end`.
- R11: `pf_start` copies the prior `al_live` to `al_prior` and suspends autoload. `pf_end` lifts the suspension only when `pf_end_arg` is 1.
- R12: While `freeze` is high, no new request is raised, autoload triggers are dropped, and a preload walk pauses. The walk continues once `freeze` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| al_enable | input | 1 | Autoload enable |
| al_order | input | 1 | Autoload direction: 0 ascending, 1 descending |
| al_trigger | input | 2 | Trigger kind: 0 miss, 1 hit, 2 both, 3 none |
| win0_en | input | 1 | Window 0 enable |
| win0_base | input | ADDR_W | Window 0 start byte address |
| win0_size | input | ADDR_W | Window 0 size in bytes |
| win1_en | input | 1 | Window 1 enable |
| win1_base | input | ADDR_W | Window 1 start byte address |
| win1_size | input | ADDR_W | Window 1 size in bytes |
| lk_valid | input | 1 | A cache lookup result is present |
| lk_hit | input | 1 | The lookup hit |
| lk_addr | input | ADDR_W | Lookup byte address |
| freeze | input | 1 | Cache frozen: no new requests |
| al_suspend | input | 1 | Pulse: suspend autoload |
| al_resume | input | 1 | Pulse: resume autoload |
| al_resume_arg | input | 1 | Lift the suspension on resume |
| pf_start | input | 1 | Pulse: start a manual preload |
| pf_addr | input | ADDR_W | Preload start byte address |
| pf_size | input | ADDR_W | Preload size in bytes |
| pf_order | input | 1 | Preload direction: 0 ascending, 1 descending |
| pf_end | input | 1 | Pulse: end the preload |
| pf_end_arg | input | 1 | Lift the autoload suspension on end |
| req_valid | output | 1 | Line request valid |
| req_addr | output | ADDR_W | Line-aligned request address |
| req_ready | input | 1 | Cache accepts the request |
| al_live | output | 1 | Autoload currently active |
| al_prior | output | 1 | Autoload state captured at the last suspend or preload start |
| pf_done | output | 1 | Manual preload complete |

## Verification
Autoload is driven with hits and misses under each trigger code. The same lookup address that produces a request under one code must produce nothing under another, which separates the trigger decode from the window test. Lookups are placed on the last and first lines of a window, on a disabled window, and outside both windows, so that boundary refusal can be told apart from region refusal in each direction. A second lookup is issued while the first request is held by a low `req_ready`, which shows whether triggers are dropped or queued.

Preloads are run in both orders, from an unaligned start, with size zero and with an oversized request that must clamp. They are also run under freeze and during live autoload, so that a paused walk, a suspended autoload and the restore rule each give their own visible outcome.

// File: rtl/line_prefetch_engine.sv
module line_prefetch_engine #(
  parameter int ADDR_W      = 24,
  parameter int LINE_BYTES  = 32,
  parameter int CACHE_BYTES = 16384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              al_enable,
  input  logic              al_order,
  input  logic [1:0]        al_trigger,
  input  logic              win0_en,
  input  logic [ADDR_W-1:0] win0_base,
  input  logic [ADDR_W-1:0] win0_size,
  input  logic              win1_en,
  input  logic [ADDR_W-1:0] win1_base,
  input  logic [ADDR_W-1:0] win1_size,
  input  logic              lk_valid,
  input  logic              lk_hit,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              freeze,
  input  logic              al_suspend,
  input  logic              al_resume,
  input  logic              al_resume_arg,
  input  logic              pf_start,
  input  logic [ADDR_W-1:0] pf_addr,
  input  logic [ADDR_W-1:0] pf_size,
  input  logic              pf_order,
  input  logic              pf_end,
  input  logic              pf_end_arg,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              req_ready,
  output logic              al_live,
  output logic              al_prior,
  output logic              pf_done
);
  localparam int LB    = $clog2(LINE_BYTES);
  localparam int LA_W  = ADDR_W - LB;
  localparam int CNT_W = $clog2(CACHE_BYTES / LINE_BYTES) + 2;
  localparam logic [ADDR_W:0]   LINE_STEP = (ADDR_W+1)'(LINE_BYTES);
  localparam logic [ADDR_W-1:0] MAX_SIZE  = ADDR_W'(CACHE_BYTES);

  logic              susp, walking, w_dir, req_pl;
  logic [LA_W-1:0]   w_cur;
  logic [CNT_W-1:0]  w_cnt;

  assign al_live = al_enable && !susp;

  // autoload trigger path
  logic [ADDR_W:0] lk_x, w0_end, w1_end, sel_base, sel_end, aligned, nxt;
  logic in0, in1, trig_ok, fire_auto, fire_walk;

  assign lk_x    = {1'b0, lk_addr};
  assign w0_end  = {1'b0, win0_base} + {1'b0, win0_size};
  assign w1_end  = {1'b0, win1_base} + {1'b0, win1_size};
  assign in0     = win0_en && lk_x >= {1'b0, win0_base} && lk_x < w0_end;
  assign in1     = win1_en && lk_x >= {1'b0, win1_base} && lk_x < w1_end;
  assign sel_base = in0 ? {1'b0, win0_base} : {1'b0, win1_base};
  assign sel_end  = in0 ? w0_end : w1_end;
  assign aligned = {1'b0, lk_addr[ADDR_W-1:LB], {LB{1'b0}}};
  assign nxt     = al_order ? aligned - LINE_STEP : aligned + LINE_STEP;

  always_comb begin
    case (al_trigger)
      2'd0:    trig_ok = !lk_hit;
      2'd1:    trig_ok = lk_hit;
      2'd2:    trig_ok = 1'b1;
      default: trig_ok = 1'b0;
    endcase
  end

  assign fire_auto = lk_valid && al_live && !walking && !freeze && !req_valid &&
                     trig_ok && (in0 || in1) && !nxt[ADDR_W] &&
                     nxt >= sel_base && nxt < sel_end;

  // manual preload setup
  logic [ADDR_W-1:0] sz;
  logic [ADDR_W:0]   last_byte;
  logic [LA_W:0]     last_ln, first_ln, span;
  logic [CNT_W-1:0]  n_lines;

  assign sz        = (pf_size > MAX_SIZE) ? MAX_SIZE : pf_size;
  assign last_byte = {1'b0, pf_addr} + {1'b0, sz} - (ADDR_W+1)'(1);
  assign last_ln   = last_byte[ADDR_W:LB];
  assign first_ln  = {1'b0, pf_addr[ADDR_W-1:LB]};
  assign span      = last_ln - first_ln + (LA_W+1)'(1);
  assign n_lines   = (sz == '0) ? '0 : span[CNT_W-1:0];

  assign fire_walk = walking && !req_valid && !freeze && w_cnt != '0 &&
                     !pf_start && !pf_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_pl    <= 1'b0;
      susp      <= 1'b0;
      al_prior  <= 1'b0;
      walking   <= 1'b0;
      w_dir     <= 1'b0;
      w_cur     <= '0;
      w_cnt     <= '0;
      pf_done   <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        req_valid <= 1'b0;
        if (req_pl) begin
          w_cnt <= w_cnt - CNT_W'(1);
          w_cur <= w_dir ? w_cur - LA_W'(1) : w_cur + LA_W'(1);
        end
      end
      if (fire_auto) begin
        req_valid <= 1'b1;
        req_addr  <= nxt[ADDR_W-1:0];
        req_pl    <= 1'b0;
      end else if (fire_walk) begin
        req_valid <= 1'b1;
        req_addr  <= {w_cur, {LB{1'b0}}};
        req_pl    <= 1'b1;
      end
      if (walking && !req_valid && w_cnt == '0) begin
        walking <= 1'b0;
        pf_done <= 1'b1;
      end
      if (pf_start) begin
        al_prior <= al_live;
        susp     <= 1'b1;
        walking  <= 1'b1;
        w_cnt    <= n_lines;
        w_dir    <= pf_order;
        w_cur    <= pf_order ? last_ln[LA_W-1:0] : first_ln[LA_W-1:0];
        pf_done  <= 1'b0;
      end else if (pf_end) begin
        walking <= 1'b0;
        pf_done <= 1'b0;
        if (pf_end_arg) susp <= 1'b0;
      end else if (al_suspend) begin
        al_prior <= al_live;
        susp     <= 1'b1;
      end else if (al_resume) begin
        if (al_resume_arg) susp <= 1'b0;
      end
    end
  end

  // R7
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));
  // R7
  aligned_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[LB-1:0] == '0);
  // R12
  freeze_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> !$past(freeze));
  // R10
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_start |=> !pf_done);
  // R8
  suspend_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    al_suspend && !pf_start && !pf_end |=> !al_live);
  // R11
  restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_end && pf_end_arg && !pf_start |=> al_live || !al_enable);
endmodule

// File: tb/line_prefetch_engine_bench.sv
module line_prefetch_engine_bench;
  localparam int PERIOD = 10;
  localparam int AW = 24;

  logic clk = 0, rst_n = 0;
  logic al_enable = 0, al_order = 0;
  logic [1:0] al_trigger = 0;
  logic win0_en = 0, win1_en = 0;
  logic [AW-1:0] win0_base = 0, win0_size = 0, win1_base = 0, win1_size = 0;
  logic lk_valid = 0, lk_hit = 0;
  logic [AW-1:0] lk_addr = 0;
  logic freeze = 0, al_suspend = 0, al_resume = 0, al_resume_arg = 0;
  logic pf_start = 0, pf_order = 0, pf_end = 0, pf_end_arg = 0;
  logic [AW-1:0] pf_addr = 0, pf_size = 0;
  logic req_valid, req_ready = 1, al_live, al_prior, pf_done;
  logic [AW-1:0] req_addr;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  logic [AW-1:0] exp_q[$];
  string tag_q[$];

  always #(PERIOD/2) clk = ~clk;

  line_prefetch_engine u_line_prefetch_engine (
    .clk(clk), .rst_n(rst_n), .al_enable(al_enable), .al_order(al_order),
    .al_trigger(al_trigger), .win0_en(win0_en), .win0_base(win0_base),
    .win0_size(win0_size), .win1_en(win1_en), .win1_base(win1_base),
    .win1_size(win1_size), .lk_valid(lk_valid), .lk_hit(lk_hit),
    .lk_addr(lk_addr), .freeze(freeze), .al_suspend(al_suspend),
    .al_resume(al_resume), .al_resume_arg(al_resume_arg), .pf_start(pf_start),
    .pf_addr(pf_addr), .pf_size(pf_size), .pf_order(pf_order), .pf_end(pf_end),
    .pf_end_arg(pf_end_arg), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .al_live(al_live), .al_prior(al_prior),
    .pf_done(pf_done));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_req(logic [AW-1:0] a, string tag);
    exp_q.push_back(a);
    tag_q.push_back(tag);
  endtask

  // monitor: compares every accepted request with the scoreboard
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected request: actual %0h expected none", req_addr);
      end else begin
        automatic logic [AW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (req_addr !== e) begin
          n_fail++;
          $display("FAIL %s: actual %0h expected %0h", t, req_addr, e);
        end
      end
    end
  end

  task automatic drain(string tag, int maxc);
    for (int i = 0; i < maxc && exp_q.size() != 0; i++) step();
    repeat (4) step();
    chk({tag, " pending"}, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic lookup(logic hit, logic [AW-1:0] a);
    lk_valid = 1; lk_hit = hit; lk_addr = a;
    step();
    lk_valid = 0;
  endtask

  task automatic preload(logic [AW-1:0] a, logic [AW-1:0] s, logic o);
    pf_addr = a; pf_size = s; pf_order = o; pf_start = 1;
    step();
    pf_start = 0;
  endtask

  task automatic end_preload(logic arg);
    pf_end = 1; pf_end_arg = arg;
    step();
    pf_end = 0;
  endtask

  task automatic wait_done(int maxc);
    for (int i = 0; i < maxc && !pf_done; i++) step();
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R1
    chk("R1 req_valid", req_valid, 0);
    chk("R1 pf_done", pf_done, 0);
    chk("R1 al_prior", al_prior, 0);
    chk("R1 al_live", al_live, 0);
    rst_n = 1;
    win0_en = 1; win0_base = 24'h1000; win0_size = 24'h400;
    win1_en = 1; win1_base = 24'h8000; win1_size = 24'h200;
    al_enable = 1;
    step();
    chk("R8 live after enable", al_live, 1);

    // R2 and R4: trigger codes, ascending
    al_trigger = 0;
    expect_req(24'h1060, "R4 miss ascending");
    lookup(0, 24'h1044); repeat (3) step();
    lookup(1, 24'h1100); drain("R2 miss-only", 20);
    al_trigger = 1;
    expect_req(24'h1120, "R2 hit-only");
    lookup(1, 24'h1100); repeat (3) step();
    lookup(0, 24'h1100); drain("R2 hit-only", 20);
    al_trigger = 2;
    expect_req(24'h1120, "R2 both hit");
    lookup(1, 24'h1100); repeat (3) step();
    expect_req(24'h1220, "R2 both miss");
    lookup(0, 24'h1200); drain("R2 both", 20);
    al_trigger = 3;
    lookup(0, 24'h1100); repeat (3) step();
    lookup(1, 24'h1100); drain("R2 code3 none", 20);

    // R4 descending
    al_trigger = 2; al_order = 1;
    expect_req(24'h1020, "R4 descending");
    lookup(0, 24'h1044); drain("R4 descending", 20);

    // R5 boundaries, R3 windows
    lookup(0, 24'h1000); drain("R5 low edge", 20);
    al_order = 0;
    lookup(0, 24'h13F0); drain("R5 high edge", 20);
    expect_req(24'h8020, "R3 window1");
    lookup(0, 24'h8000); drain("R3 window1", 20);
    win1_en = 0;
    lookup(0, 24'h8000); drain("R3 disabled window", 20);
    lookup(0, 24'h4000); drain("R3 outside", 20);
    win1_en = 1;

    // R6 drop while outstanding, R7 hold
    req_ready = 0;
    expect_req(24'h1060, "R6 first kept");
    lookup(0, 24'h1044);
    lookup(0, 24'h1100);
    repeat (3) step();
    chk("R7 valid held", req_valid, 1);
    chk("R7 addr held", req_addr, 24'h1060);
    req_ready = 1;
    drain("R6 second dropped", 20);

    // R8 suspend / resume
    al_suspend = 1; step(); al_suspend = 0;
    chk("R8 prior live", al_prior, 1);
    chk("R8 suspended", al_live, 0);
    lookup(0, 24'h1044); drain("R8 suspended ignores", 20);
    al_resume = 1; al_resume_arg = 0; step(); al_resume = 0;
    chk("R8 resume arg0", al_live, 0);
    al_suspend = 1; step(); al_suspend = 0;
    chk("R8 prior not live", al_prior, 0);
    al_resume = 1; al_resume_arg = 1; step(); al_resume = 0;
    chk("R8 resume arg1", al_live, 1);
    al_enable = 0; step();
    chk("R8 disable", al_live, 0);
    al_enable = 1; step();

    // R12 freeze drops triggers
    freeze = 1;
    lookup(0, 24'h1044); drain("R12 frozen trigger", 20);

    // R12 walk paused while frozen, R11 suspend on start
    preload(24'h2000, 24'h40, 0);
    chk("R11 prior", al_prior, 1);
    chk("R11 suspended", al_live, 0);
    repeat (5) step();
    chk("R12 no request frozen", req_valid, 0);
    chk("R12 not done frozen", pf_done, 0);
    expect_req(24'h2000, "R12 resumed walk 0");
    expect_req(24'h2020, "R12 resumed walk 1");
    freeze = 0;
    wait_done(50);
    chk("R10 done", pf_done, 1);
    drain("R12 walk", 20);
    end_preload(1);
    chk("R10 cleared by end", pf_done, 0);
    chk("R11 restored", al_live, 1);

    // R9 ascending unaligned, autoload ignored during walk
    req_ready = 0;
    preload(24'h2010, 24'h50, 0);
    lookup(0, 24'h1044);
    expect_req(24'h2000, "R9 asc 0");
    expect_req(24'h2020, "R9 asc 1");
    expect_req(24'h2040, "R9 asc 2");
    req_ready = 1;
    wait_done(50);
    chk("R10 done asc", pf_done, 1);
    drain("R9 asc", 20);
    end_preload(0);
    chk("R11 end arg0 stays off", al_live, 0);

    // R9 descending
    preload(24'h3000, 24'h40, 1);
    expect_req(24'h3020, "R9 desc 0");
    expect_req(24'h3000, "R9 desc 1");
    wait_done(50);
    chk("R10 done desc", pf_done, 1);
    drain("R9 desc", 20);

    // R9 size zero
    preload(24'h5000, 24'h0, 0);
    step();
    chk("R10 done size0", pf_done, 1);
    drain("R9 size0", 10);

    // R9 clamp to cache size
    preload(24'h0, 24'h100000, 0);
    for (int i = 0; i < 512; i++) expect_req(AW'(i * 32), "R9 clamp");
    wait_done(3000);
    chk("R10 done clamp", pf_done, 1);
    drain("R9 clamp", 100);
    end_preload(1);
    chk("R11 restore after clamp", al_live, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule